// File: doc/BRIEF.md
# Paired Flash Buffered-Write Sequencer

This block runs erase, buffered programming and read-back verification on two 16-bit flash devices that sit side by side on one 32-bit data bus and behave as a single wide memory. The low byte lane carries the command and status byte of one device and the next lane carries those of the other. Every command byte is therefore written to both lanes in one bus write. Every status decision waits until both devices report ready, and then inspects each error flag on both lanes.

A controller hands the block a block number and one of four operations: start an erase, wait for an erase to finish, program a whole block, or verify a whole block. The block issues its own reads and writes on a simple request/acknowledge bus master port. It takes the words to program or compare, in ascending address order, from a data-source port. Each operation ends with a one-cycle done pulse and a result code. A flash write-enable output frames the programming session.

Top module: `dual_flash_seq`

## Requirements
- R1: Every command write puts the command byte c on the bus as {16'h0000, c, c} at the block base address (block number followed by BLK_BITS zero bits).
- R2: Erase-start (op 0) writes 0x2020 and then 0xD0D0, asserts flash_we, and ends with code 0.
- R3: Erase-wait (op 1) issues status reads at the block base until bits 7 and 15 are both set. It then reports code 1 if bit 5 or bit 13 is set, and code 0 otherwise.
- R4: Write-block (op 2) handles each 64-byte buffer in this order. It writes 0xE8E8 and reads status, repeating this pair until bits 7 and 15 are both set. It then writes the count 0x0F0F, sixteen source words at consecutive word addresses, and 0xD0D0. It then polls status until bits 7 and 15 are both set.
- R5: After a buffer's final poll, the checks run in priority order: bit 3 or bit 11 gives code 2, else bit 1 or bit 9 gives code 3, else bit 4 or bit 12 gives code 4.
- R6: On code 1, 2, 3, 4 or 6 the block writes 0x5050 and then 0xFFFF, then lowers flash_we before done.
- R7: A block holds BLK_BYTES/64 buffers. flash_we is high for every data write and is low at done.
- R8: Verify-block (op 3) writes 0xFFFF, then reads each word and compares it with the source word. It stops at the first mismatch with code 5, and gives code 0 when all words match.
- R9: A status read that returns not-ready after POLL_LIMIT cycles of polling ends the operation with code 6.
- R10: done is a single-cycle pulse. err_code holds until the next request is accepted, and requests are accepted only while req_ready is high.
- R11: A bus request that is not yet acknowledged stays high with its address, direction and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 0 erase-start, 1 erase-wait, 2 write-block, 3 verify-block |
| req_blk | input | ADDR_W-BLK_BITS | Target block number |
| req_ready | output | 1 | High when idle and able to accept a request |
| bus_req | output | 1 | Bus transfer request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer complete |
| src_valid | input | 1 | Source word available; must stay high until popped |
| src_data | input | 32 | Current source word |
| src_pop | output | 1 | Current source word consumed |
| flash_we | output | 1 | Flash write-enable for the programming session |
| done | output | 1 | Operation finished (one cycle) |
| err_code | output | 3 | 0 ok, 1 erase, 2 voltage, 3 protect, 4 program, 5 verify, 6 timeout |

## Verification
Some properties can be checked on every cycle, and the assertions cover those:
- the bus holds a request stable until it is acknowledged;
- command writes carry a duplicated byte in both lanes;
- flash_we is high for every data write;
- done lasts one cycle;
- the result code holds steady while idle;
- flash_we is low whenever an error completes;
- the poll timer expires only while polling.

Other behaviour can only be shown by the directed scenarios, against a bench flash model that logs every transfer:
- the exact command order of erase and programming;
- the retry of the buffer-request write;
- the priority among simultaneous program error flags;
- the cleanup writes;
- verification stopping at the first mismatching word;
- the poll timeout.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic [1:0] {
        OP_ERASE_START  = 2'd0,
        OP_ERASE_WAIT   = 2'd1,
        OP_WRITE_BLOCK  = 2'd2,
        OP_VERIFY_BLOCK = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_ERASE   = 3'd1,
        ERR_VPP     = 3'd2,
        ERR_PROTECT = 3'd3,
        ERR_PROGRAM = 3'd4,
        ERR_VERIFY  = 3'd5,
        ERR_TIMEOUT = 3'd6
    } err_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ER_SETUP,
        S_ER_CONF,
        S_ER_POLL,
        S_PG_E8,
        S_PG_XSR,
        S_PG_CNT,
        S_PG_DATA,
        S_PG_CONF,
        S_PG_POLL,
        S_VF_RA,
        S_VF_RD,
        S_ERR_CLR,
        S_ERR_RA,
        S_DONE
    } state_t;

    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_BUF_WR   = 8'hE8;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;

    // A command goes to both devices in one bus write.
    function automatic logic [31:0] dup_cmd(input logic [7:0] c);
        return {16'h0000, c, c};
    endfunction

endpackage

// File: rtl/dfs_status_eval.sv
module dfs_status_eval #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] status,
    output logic               all_ready,
    output logic               erase_fail,
    output logic               vpp_fail,
    output logic               protect_fail,
    output logic               prog_fail
);
    logic [LANES-1:0] lane_rdy;
    logic [LANES-1:0] lane_er;
    logic [LANES-1:0] lane_vpp;
    logic [LANES-1:0] lane_prot;
    logic [LANES-1:0] lane_prog;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] sb;
        assign sb           = status[l*8 +: 8];
        assign lane_rdy[l]  = sb[7];
        assign lane_er[l]   = sb[5];
        assign lane_prog[l] = sb[4];
        assign lane_vpp[l]  = sb[3];
        assign lane_prot[l] = sb[1];
    end

    // Ready only when every device agrees; any lane may raise an error.
    assign all_ready    = &lane_rdy;
    assign erase_fail   = |lane_er;
    assign vpp_fail     = |lane_vpp;
    assign protect_fail = |lane_prot;
    assign prog_fail    = |lane_prog;

endmodule

// File: rtl/dfs_poll_timer.sv
module dfs_poll_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
    localparam logic [CW-1:0] ONE_C = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q < LIM_C)
            cnt_d = cnt_q + ONE_C;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q >= LIM_C);

    // R9: the timer can only have run out while a poll loop was active
    p_expire_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> $past(run));

endmodule

// File: rtl/dual_flash_seq.sv
module dual_flash_seq
    import dfs_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int BLK_BYTES     = 262144,
    parameter int DEV_BUF_BYTES = 32,
    parameter int POLL_LIMIT    = 1000000,
    localparam int BLK_BITS     = $clog2(BLK_BYTES),
    localparam int BLKN_W       = ADDR_W - BLK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BLKN_W-1:0] req_blk,
    output logic              req_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack,
    input  logic              src_valid,
    input  logic [31:0]       src_data,
    output logic              src_pop,
    output logic              flash_we,
    output logic              done,
    output logic [2:0]        err_code
);
    localparam int WIDX_W    = BLK_BITS - 2;
    localparam int BUF_WORDS = (DEV_BUF_BYTES * 2) / 4;
    localparam int BW_BITS   = $clog2(BUF_WORDS);
    localparam logic [7:0] CNT_BYTE = 8'(DEV_BUF_BYTES / 2 - 1);
    localparam logic [WIDX_W:0] WIDX_ONE = {{WIDX_W{1'b0}}, 1'b1};

    typedef struct packed {
        state_t            st;
        logic [BLKN_W-1:0] blk;
        logic [WIDX_W:0]   widx;
        err_t              err;
        logic              we;
    } regs_t;

    regs_t r_d, r_q;

    logic st_rdy, st_er, st_vpp, st_prot, st_prog;
    logic polling, poll_expired;
    logic word_addr;

    dfs_status_eval #(.LANES(2)) u_status (
        .status      (bus_rdata[15:0]),
        .all_ready   (st_rdy),
        .erase_fail  (st_er),
        .vpp_fail    (st_vpp),
        .protect_fail(st_prot),
        .prog_fail   (st_prog)
    );

    assign polling = (r_q.st == S_ER_POLL) || (r_q.st == S_PG_E8) ||
                     (r_q.st == S_PG_XSR)  || (r_q.st == S_PG_POLL);

    dfs_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (polling),
        .expired(poll_expired)
    );

    // Bus side, decoded from the current state
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        word_addr = 1'b0;
        unique case (r_q.st)
            S_ER_SETUP: begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_ERASE);    end
            S_ER_CONF:  begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_CONFIRM);  end
            S_PG_E8:    begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_BUF_WR);   end
            S_PG_CNT:   begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CNT_BYTE);     end
            S_PG_CONF:  begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_CONFIRM);  end
            S_VF_RA:    begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_RD_ARRAY); end
            S_ERR_CLR:  begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_CLR_STAT); end
            S_ERR_RA:   begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = dup_cmd(CMD_RD_ARRAY); end
            S_ER_POLL, S_PG_XSR, S_PG_POLL: bus_req = 1'b1;
            S_PG_DATA: begin
                bus_req   = src_valid;
                bus_we    = 1'b1;
                bus_wdata = src_data;
                word_addr = 1'b1;
            end
            S_VF_RD: begin
                bus_req   = src_valid;
                word_addr = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_addr  = {r_q.blk, word_addr ? {r_q.widx[WIDX_W-1:0], 2'b00} : {BLK_BITS{1'b0}}};
    assign src_pop   = bus_ack && ((r_q.st == S_PG_DATA) || (r_q.st == S_VF_RD));
    assign req_ready = (r_q.st == S_IDLE);
    assign done      = (r_q.st == S_DONE);
    assign flash_we  = r_q.we;
    assign err_code  = r_q.err;

    // Sequencer next-state
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: if (req_valid) begin
                r_d.err  = ERR_NONE;
                r_d.blk  = req_blk;
                r_d.widx = '0;
                unique case (op_t'(req_op))
                    OP_ERASE_START: begin r_d.we = 1'b1; r_d.st = S_ER_SETUP; end
                    OP_ERASE_WAIT:  r_d.st = S_ER_POLL;
                    OP_WRITE_BLOCK: begin r_d.we = 1'b1; r_d.st = S_PG_E8; end
                    default:        r_d.st = S_VF_RA;
                endcase
            end
            S_ER_SETUP: if (bus_ack) r_d.st = S_ER_CONF;
            S_ER_CONF:  if (bus_ack) r_d.st = S_DONE;
            S_ER_POLL: if (bus_ack) begin
                if (st_rdy) begin
                    if (st_er) begin
                        r_d.err = ERR_ERASE;
                        r_d.st  = S_ERR_CLR;
                    end else begin
                        r_d.st = S_DONE;
                    end
                end else if (poll_expired) begin
                    r_d.err = ERR_TIMEOUT;
                    r_d.st  = S_ERR_CLR;
                end
            end
            S_PG_E8: if (bus_ack) r_d.st = S_PG_XSR;
            S_PG_XSR: if (bus_ack) begin
                if (st_rdy) begin
                    r_d.st = S_PG_CNT;
                end else if (poll_expired) begin
                    r_d.err = ERR_TIMEOUT;
                    r_d.st  = S_ERR_CLR;
                end else begin
                    r_d.st = S_PG_E8;
                end
            end
            S_PG_CNT: if (bus_ack) r_d.st = S_PG_DATA;
            S_PG_DATA: if (bus_ack) begin
                r_d.widx = r_q.widx + WIDX_ONE;
                if (&r_q.widx[BW_BITS-1:0])
                    r_d.st = S_PG_CONF;
            end
            S_PG_CONF: if (bus_ack) r_d.st = S_PG_POLL;
            S_PG_POLL: if (bus_ack) begin
                if (st_rdy) begin
                    if (st_vpp) begin
                        r_d.err = ERR_VPP;
                        r_d.st  = S_ERR_CLR;
                    end else if (st_prot) begin
                        r_d.err = ERR_PROTECT;
                        r_d.st  = S_ERR_CLR;
                    end else if (st_prog) begin
                        r_d.err = ERR_PROGRAM;
                        r_d.st  = S_ERR_CLR;
                    end else if (r_q.widx[WIDX_W]) begin
                        r_d.we = 1'b0;
                        r_d.st = S_DONE;
                    end else begin
                        r_d.st = S_PG_E8;
                    end
                end else if (poll_expired) begin
                    r_d.err = ERR_TIMEOUT;
                    r_d.st  = S_ERR_CLR;
                end
            end
            S_VF_RA: if (bus_ack) r_d.st = S_VF_RD;
            S_VF_RD: if (bus_ack) begin
                if (bus_rdata != src_data) begin
                    r_d.err = ERR_VERIFY;
                    r_d.we  = 1'b0;
                    r_d.st  = S_DONE;
                end else begin
                    r_d.widx = r_q.widx + WIDX_ONE;
                    if (&r_q.widx[WIDX_W-1:0])
                        r_d.st = S_DONE;
                end
            end
            S_ERR_CLR: if (bus_ack) r_d.st = S_ERR_RA;
            S_ERR_RA: if (bus_ack) begin
                r_d.we = 1'b0;
                r_d.st = S_DONE;
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{st: S_IDLE, blk: '0, widx: '0, err: ERR_NONE, we: 1'b0};
        else
            r_q <= r_d;
    end

    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    p_cmd_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (r_q.st != S_PG_DATA) |->
            (bus_wdata[31:16] == 16'h0) && (bus_wdata[15:8] == bus_wdata[7:0]));

    p_data_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && (r_q.st == S_PG_DATA) |-> flash_we);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && !req_valid |=> $stable(err_code));

    p_err_we_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && (err_code != 3'd0) |-> !flash_we);

endmodule

// File: tb/dual_flash_seq_tb_top.sv
module dual_flash_seq_tb_top;
    localparam int ADDR_W   = 12;
    localparam int BLK      = 256;
    localparam int BLK_BITS = 8;
    localparam int NBUF     = BLK / 64;
    localparam int NWORD    = BLK / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [3:0]        req_blk = '0;
    logic              req_ready;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata = '0;
    logic              bus_ack = 1'b0;
    logic              src_valid;
    logic [31:0]       src_data;
    logic              src_pop;
    logic              flash_we, done;
    logic [2:0]        err_code;

    dual_flash_seq #(
        .ADDR_W(ADDR_W), .BLK_BYTES(BLK), .DEV_BUF_BYTES(32), .POLL_LIMIT(40)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk), .req_ready(req_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
        .flash_we(flash_we), .done(done), .err_code(err_code)
    );

    // ---------------- flash pair model and source ----------------
    logic [31:0]       mem [0:1023];
    logic [ADDR_W-1:0] log_a [0:511];
    logic [31:0]       log_d [0:511];
    int log_n = 0, rd_n = 0, we_viol = 0, hold_viol = 0;
    int busy_cfg = 0, busy_left = 0, e8_left = 0, data_left = 0;
    logic [31:0] st_err = '0;
    logic [31:0] last_cmd = 32'h0;
    logic pend = 1'b0;
    logic [ADDR_W-1:0] pend_a = '0;

    logic [31:0] src_mem [0:63];
    int src_idx = 0, src_len = 0;
    assign src_valid = (src_idx < src_len);
    assign src_data  = src_mem[src_idx[5:0]];

    always @(posedge clk) begin
        if (pend && (!bus_req || bus_addr != pend_a)) hold_viol++;
        pend   = bus_req && !bus_ack;
        pend_a = bus_addr;
        if (src_pop) src_idx <= src_idx + 1;
        if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (log_n < 512) begin
                    log_a[log_n] = bus_addr;
                    log_d[log_n] = bus_wdata;
                end
                log_n++;
                if (data_left > 0) begin
                    mem[bus_addr[11:2]] = bus_wdata;
                    data_left--;
                    if (!flash_we) we_viol++;
                end else begin
                    last_cmd = bus_wdata;
                    if (bus_wdata == 32'h0F0F) data_left = 16;
                    if (bus_wdata == 32'hD0D0) busy_left = busy_cfg;
                end
            end else begin
                rd_n++;
                if (last_cmd == 32'hFFFF)
                    bus_rdata <= mem[bus_addr[11:2]];
                else if (last_cmd == 32'hE8E8) begin
                    if (e8_left > 0) begin e8_left--; bus_rdata <= 32'h0; end
                    else bus_rdata <= 32'h8080;
                end else begin
                    if (busy_left > 0) begin busy_left--; bus_rdata <= 32'h0; end
                    else bus_rdata <= 32'h8080 | st_err;
                end
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5000000 ^ (i * 32'h01030507);
    endfunction

    task automatic clear_log();
        log_n = 0; rd_n = 0;
    endtask

    task automatic load_src(input int len);
        for (int i = 0; i < 64; i++) src_mem[i] = pat(i);
        src_len = len;
        src_idx = 0;
    endtask

    // Issue a request and wait for done; checks the pulse width (R10)
    task automatic run_op(input logic [1:0] op, input logic [3:0] blk);
        int w;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_blk = blk;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R10 done seen", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        chk(flash_we == 1'b0, "R7 reset we", flash_we, 0);
        chk(err_code == 3'd0, "R10 reset err", err_code, 0);
        chk(bus_req == 1'b0, "R11 reset bus idle", bus_req, 0);
    endtask

    task automatic t_erase_ok();
        busy_cfg = 3; st_err = '0; clear_log();
        run_op(2'd0, 4'd2);
        chk(log_n == 2, "R2 erase write count", log_n, 2);
        chk(log_a[0] == 12'h200 && log_a[1] == 12'h200, "R1 erase address", log_a[1], 12'h200);
        chk(log_d[0] == 32'h2020, "R1 erase setup byte", log_d[0], 32'h2020);
        chk(log_d[1] == 32'hD0D0, "R2 erase confirm", log_d[1], 32'hD0D0);
        chk(flash_we == 1'b1 && err_code == 3'd0, "R2 erase start result", err_code, 0);
        clear_log();
        run_op(2'd1, 4'd2);
        chk(rd_n == 4, "R3 poll reads until ready", rd_n, 4);
        chk(log_n == 0 && err_code == 3'd0, "R3 erase wait clean", err_code, 0);
    endtask

    task automatic t_erase_fail();
        busy_cfg = 0; st_err = 32'h2000;
        run_op(2'd0, 4'd3);
        clear_log();
        run_op(2'd1, 4'd3);
        chk(err_code == 3'd1, "R3 erase error code", err_code, 1);
        chk(log_n == 2 && log_d[0] == 32'h5050 && log_d[1] == 32'hFFFF, "R6 erase cleanup", log_d[0], 32'h5050);
        chk(flash_we == 1'b0, "R6 we dropped", flash_we, 0);
        st_err = '0;
    endtask

    task automatic t_write_ok();
        int bad;
        busy_cfg = 1; st_err = '0; e8_left = 0; we_viol = 0;
        load_src(NWORD); clear_log();
        run_op(2'd2, 4'd1);
        chk(log_n == NBUF * 19, "R7 write count per block", log_n, NBUF * 19);
        bad = 0;
        for (int b = 0; b < NBUF; b++) begin
            int k;
            k = b * 19;
            if (log_d[k] != 32'hE8E8 || log_a[k] != 12'h100) bad++;
            if (log_d[k+1] != 32'h0F0F) bad++;
            for (int j = 0; j < 16; j++)
                if (log_d[k+2+j] != pat(b*16+j) || log_a[k+2+j] != 12'(12'h100 + b*64 + j*4)) bad++;
            if (log_d[k+18] != 32'hD0D0) bad++;
        end
        chk(bad == 0, "R4 buffer sequence", bad, 0);
        bad = 0;
        for (int i = 0; i < NWORD; i++) if (mem[64 + i] != pat(i)) bad++;
        chk(bad == 0, "R4 programmed content", bad, 0);
        chk(we_viol == 0, "R7 we during data", we_viol, 0);
        chk(flash_we == 1'b0 && err_code == 3'd0, "R7 we released ok", flash_we, 0);
        chk(src_idx == NWORD, "R7 words consumed", src_idx, NWORD);
    endtask

    task automatic t_e8_retry();
        busy_cfg = 0; e8_left = 2; load_src(NWORD); clear_log();
        run_op(2'd2, 4'd5);
        chk(log_d[0] == 32'hE8E8 && log_d[1] == 32'hE8E8 && log_d[2] == 32'hE8E8,
            "R4 buffer request retried", log_d[2], 32'hE8E8);
        chk(log_d[3] == 32'h0F0F, "R4 count after ready", log_d[3], 32'h0F0F);
        chk(log_n == NBUF * 19 + 2, "R4 retry write total", log_n, NBUF * 19 + 2);
    endtask

    task automatic t_prio(input logic [31:0] flags, input int exp_code);
        busy_cfg = 0; e8_left = 0; st_err = flags; load_src(NWORD); clear_log();
        run_op(2'd2, 4'd6);
        chk(err_code == 3'(exp_code), "R5 error priority", err_code, exp_code);
        chk(log_n == 21 && log_d[19] == 32'h5050 && log_d[20] == 32'hFFFF,
            "R6 program cleanup", log_n, 21);
        chk(flash_we == 1'b0, "R6 we low after program error", flash_we, 0);
        st_err = '0;
    endtask

    task automatic t_verify_ok();
        load_src(NWORD); clear_log();
        run_op(2'd3, 4'd1);
        chk(log_n == 1 && log_d[0] == 32'hFFFF && log_a[0] == 12'h100, "R8 read array first", log_d[0], 32'hFFFF);
        chk(rd_n == NWORD, "R8 all words read", rd_n, NWORD);
        chk(err_code == 3'd0, "R8 verify pass", err_code, 0);
    endtask

    task automatic t_verify_bad();
        load_src(NWORD); src_mem[10] = src_mem[10] ^ 32'h1; clear_log();
        run_op(2'd3, 4'd1);
        chk(err_code == 3'd5, "R8 verify mismatch code", err_code, 5);
        chk(rd_n == 11, "R8 stop at first mismatch", rd_n, 11);
    endtask

    task automatic t_timeout();
        busy_cfg = 100000;
        run_op(2'd0, 4'd7);
        clear_log();
        run_op(2'd1, 4'd7);
        chk(err_code == 3'd6, "R9 timeout code", err_code, 6);
        chk(log_n == 2 && log_d[0] == 32'h5050 && log_d[1] == 32'hFFFF, "R9 timeout cleanup", log_n, 2);
        busy_cfg = 0; busy_left = 0;
        repeat (5) @(negedge clk);
        chk(err_code == 3'd6 && req_ready == 1'b1, "R10 code held while idle", err_code, 6);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) src_mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_erase_ok();
        t_erase_fail();
        t_write_ok();
        t_e8_retry();
        t_prio(32'h0812, 2);
        t_prio(32'h1002, 3);
        t_prio(32'h1010, 4);
        t_verify_ok();
        t_verify_bad();
        t_timeout();
        chk(hold_viol == 0, "R11 request held until ack", hold_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule